// File: doc/BRIEF.md
# Codec Control Word Double Buffer

This block keeps a pair of codec control words that software loads together. The serial frame composer never reads the written copy directly. It reads a shadow copy instead, and the block refreshes that shadow only at a frame boundary. As a result, each frame carries two control words that belong to the same write, and no frame sees a change partway through. Between refreshes the shadow pair stays constant, so every frame repeats it.

A busy flag shows that a written pair is still waiting to reach the shadow copy. Software polls the flag and writes the next pair only after it falls. This lets successive frames carry different control words, which is useful during codec start-up. No interrupt is raised. A write made while the flag is high is allowed but not recommended: it replaces the waiting pair.

Top module: `ctl_word_buffer`

## Requirements
- R1: While reset is asserted and after it is released, busy is 0 and both shadow words are 0. The pending words are also 0, so a frame pulse after reset leaves the shadow at 0.
- R2: A write strobe (`wrEn`=1) sets busy to 1 in the following cycle.
- R3: The shadow words change only in a cycle that follows a frame pulse given while busy was 1. A write on its own never changes them.
- R4: A frame pulse given while busy is 1 copies both pending words into the shadow together, in the following cycle. If no write comes in the same cycle, busy returns to 0 at that same time.
- R5: A frame pulse given while busy is 0 leaves both shadow words unchanged, so the same pair is repeated.
- R6: A write made while busy is 1 replaces both pending words and busy stays 1. The next transfer delivers only the latest pair.
- R7: When a write and a frame pulse arrive in the same cycle while busy is 1, the shadow receives the pair pending before that write. Busy stays 1, and the new pair moves across at the next frame pulse.
- R8: When a write and a frame pulse arrive in the same cycle while busy is 0, no transfer happens and busy becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe for a new pair |
| wrCtl1 | input | 16 | First control word to write |
| wrCtl2 | input | 16 | Second control word to write |
| frameTick | input | 1 | One-cycle frame boundary pulse from the serializer |
| shadowCtl1 | output | 16 | First control word sent in frames |
| shadowCtl2 | output | 16 | Second control word sent in frames |
| busy | output | 1 | High while a written pair waits for transfer |

## Verification
The hardest cases to reach are the collisions: a write that lands in the same cycle as a frame pulse, and a second write made while the first pair is still waiting. In both cases the pending words have to be told apart from the transmitted words. The directed tasks produce these cases by loading a known pending pair first and then driving the strobe and the pulse together in a single cycle. The bench then checks the shadow output at that frame and again at the next frame pulse, which separates the old pair from the new one.

// File: rtl/ctl_word_buffer_pkg.sv
package ctl_word_buffer_pkg;
  // Number of control words moved together as one pair
  localparam int NUM_WORDS = 2;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadPending;  // capture the written words
    logic loadShadow;   // move pending words into the shadow copy
  } ctlStrobes_t;
endpackage

// File: rtl/ctl_word_buffer_ctrl.sv
module ctl_word_buffer_ctrl
  import ctl_word_buffer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        frameTick,
  output ctlStrobes_t strobes,
  output logic        busy
);
  logic busyQ;
  logic busyD;

  // A transfer is due only when a pair is waiting at a frame boundary
  always_comb begin
    strobes.loadPending = wrEn;
    strobes.loadShadow  = frameTick && busyQ;
  end

  // A new write always leaves a pair waiting; otherwise a transfer empties it
  always_comb begin
    busyD = busyQ;
    if (wrEn)
      busyD = 1'b1;
    else if (strobes.loadShadow)
      busyD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= busyD;
  end

  assign busy = busyQ;
endmodule

// File: rtl/ctl_word_buffer_dp.sv
module ctl_word_buffer_dp
  import ctl_word_buffer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobes_t                      strobes,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] wrWords,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] shadowWords
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] pendingQ;
  logic [NUM_WORDS-1:0][WORD_W-1:0] shadowQ;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    // Shadow copies the value pending before any write in this same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendingQ[w] <= '0;
        shadowQ[w]  <= '0;
      end else begin
        if (strobes.loadShadow)  shadowQ[w]  <= pendingQ[w];
        if (strobes.loadPending) pendingQ[w] <= wrWords[w];
      end
    end
  end

  assign shadowWords = shadowQ;
endmodule

// File: rtl/ctl_word_buffer.sv
module ctl_word_buffer
  import ctl_word_buffer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrCtl1,
  input  logic [WORD_W-1:0] wrCtl2,
  input  logic              frameTick,
  output logic [WORD_W-1:0] shadowCtl1,
  output logic [WORD_W-1:0] shadowCtl2,
  output logic              busy
);
  ctlStrobes_t                      strobes;
  logic [NUM_WORDS-1:0][WORD_W-1:0] wrWords;
  logic [NUM_WORDS-1:0][WORD_W-1:0] shadowWords;

  assign wrWords[0] = wrCtl1;
  assign wrWords[1] = wrCtl2;

  ctl_word_buffer_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .frameTick (frameTick),
    .strobes   (strobes),
    .busy      (busy)
  );

  ctl_word_buffer_dp #(.WORD_W(WORD_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrWords     (wrWords),
    .shadowWords (shadowWords)
  );

  assign shadowCtl1 = shadowWords[0];
  assign shadowCtl2 = shadowWords[1];
endmodule

// File: rtl/ctl_word_buffer_chk.sv
module ctl_word_buffer_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              frameTick,
  input logic [WORD_W-1:0] shadowCtl1,
  input logic [WORD_W-1:0] shadowCtl2,
  input logic              busy
);
  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> busy);

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(frameTick && busy) |=> ($stable(shadowCtl1) && $stable(shadowCtl2)));

  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && busy && !wrEn) |=> !busy);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameTick) |=> busy);

  assert_collide_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && busy && wrEn) |=> busy);

  assert_idle_stays_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrEn) |=> !busy);
endmodule

bind ctl_word_buffer ctl_word_buffer_chk #(.WORD_W(WORD_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .frameTick  (frameTick),
  .shadowCtl1 (shadowCtl1),
  .shadowCtl2 (shadowCtl2),
  .busy       (busy)
);

// File: tb/sim_ctl_word_buffer.sv
module sim_ctl_word_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrCtl1 = '0;
  logic [15:0] wrCtl2 = '0;
  logic        frameTick = 1'b0;
  logic [15:0] shadowCtl1;
  logic [15:0] shadowCtl2;
  logic        busy;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctl_word_buffer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCtl1(wrCtl1), .wrCtl2(wrCtl2),
    .frameTick(frameTick), .shadowCtl1(shadowCtl1), .shadowCtl2(shadowCtl2),
    .busy(busy)
  );

  task automatic check(string req, logic [15:0] e1, logic [15:0] e2, logic eb);
    checks++;
    if (shadowCtl1 !== e1 || shadowCtl2 !== e2 || busy !== eb) begin
      failures++;
      $display("FAIL %s: shadow=%h/%h busy=%b expected shadow=%h/%h busy=%b",
               req, shadowCtl1, shadowCtl2, busy, e1, e2, eb);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, return at the next falling edge
  task automatic step(logic we, logic [15:0] a, logic [15:0] b, logic tk);
    @(negedge clk);
    wrEn = we; wrCtl1 = a; wrCtl2 = b; frameTick = tk;
    @(negedge clk);
    wrEn = 1'b0; frameTick = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 in reset", 16'h0, 16'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 16'h0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R1 pending zero", 16'h0, 16'h0, 1'b0);
  endtask

  task automatic testWriteThenTransfer();
    step(1'b1, 16'hA111, 16'hA222, 1'b0);
    check("R2 busy after write", 16'h0, 16'h0, 1'b1);
    step(1'b0, 16'h0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 16'h0, 1'b0);
    check("R3 shadow held while waiting", 16'h0, 16'h0, 1'b1);
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R4 transfer at frame", 16'hA111, 16'hA222, 1'b0);
  endtask

  task automatic testRepeat();
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R5 repeated pair", 16'hA111, 16'hA222, 1'b0);
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R5 repeated pair again", 16'hA111, 16'hA222, 1'b0);
  endtask

  task automatic testOverwrite();
    step(1'b1, 16'hB001, 16'hB002, 1'b0);
    step(1'b1, 16'hC001, 16'hC002, 1'b0);
    check("R6 busy kept on overwrite", 16'hA111, 16'hA222, 1'b1);
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R6 latest pair sent", 16'hC001, 16'hC002, 1'b0);
  endtask

  task automatic testCollideBusy();
    step(1'b1, 16'hD001, 16'hD002, 1'b0);
    step(1'b1, 16'hE001, 16'hE002, 1'b1);
    check("R7 older pair sent on collision", 16'hD001, 16'hD002, 1'b1);
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R7 newer pair at next frame", 16'hE001, 16'hE002, 1'b0);
  endtask

  task automatic testCollideIdle();
    step(1'b1, 16'hF001, 16'hF002, 1'b1);
    check("R8 no transfer on idle collision", 16'hE001, 16'hE002, 1'b1);
    step(1'b0, 16'h0, 16'h0, 1'b1);
    check("R8 pair sent at next frame", 16'hF001, 16'hF002, 1'b0);
  endtask

  task automatic testResetWhileBusy();
    step(1'b1, 16'h1234, 16'h5678, 1'b0);
    check("R2 busy before reset", 16'hF001, 16'hF002, 1'b1);
    doReset();
  endtask

  initial begin
    doReset();
    testWriteThenTransfer();
    testRepeat();
    testOverwrite();
    testCollideBusy();
    testCollideIdle();
    testResetWhileBusy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule